// File: doc/BRIEF.md
# Merged Variable-Length Bit Writer

This block sits behind an entropy coder that settles a variable number of output bits for each input symbol. For every symbol it receives a leading bit, a count of follow bits (each follow bit is the complement of the leading bit) and a short group of remaining bits. It turns these into writes to a bit-addressed output store, with exactly one write per symbol. It does this by holding each symbol's remaining bits back for one cycle. They are then placed at the front of the next symbol's write, ahead of that symbol's leading bit, so the emitted order is kept.

A flush request forces the held-back bits out. On its own, a flush produces a write that carries only the held bits. Raised together with a symbol, a flush produces one write that carries everything, including that symbol's own remaining bits. The block also keeps a sequential read-address counter for reading the stream back one location per read cycle. Every write presents its payload packed from the top bit down, with its width and its starting bit address, on registered outputs one cycle after the request.

Top module: `merged_bit_writer`

## Requirements
- R1: While reset is high and in the cycle after it, `wr_en` is 0 and `wr_addr` and `rd_addr` are 0. Nothing is held back after reset.
- R2: A cycle with `sym_valid` high gives exactly one write (`wr_en` high) in the next cycle. A cycle with neither `sym_valid` nor `flush` gives no write in the next cycle.
- R3: A symbol's write contains, in emission order, the bits held back from the previous symbol, then `lead_bit`, then `follow_cnt` copies of the inverse of `lead_bit`. The first emitted bit is at `wr_data[DATA_W-1]` and later bits go down from there. All bits below the payload are 0, and `wr_width` equals the payload bit count.
- R4: A symbol's remaining bits (`rem_cnt` bits, taken MSB-first from `rem_bits[rem_cnt-1]` down to `rem_bits[0]`) are not part of its own write unless `flush` is high. They open the next write.
- R5: `flush` without `sym_valid` writes only the held-back bits, with `wr_width` equal to their count, and empties the hold. If nothing is held back, no write occurs.
- R6: `flush` together with `sym_valid` gives one write. It holds the held-back bits, the leading bit, the follow bits and then the symbol's own remaining bits, and it leaves the hold empty.
- R7: The first write after reset has `wr_addr` 0. Each later write has `wr_addr` equal to the previous write's `wr_addr` plus its `wr_width`. `wr_addr` holds its value between writes.
- R8: `rd_addr` increases by one in the cycle after every cycle with `rd_en` high, and holds its value otherwise.
- R9: Bits of `rem_bits` at positions `rem_cnt` and above have no effect on any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | A symbol is presented this cycle |
| lead_bit | input | 1 | Leading bit of the symbol |
| follow_cnt | input | FC_W | Number of follow bits (inverse of the leading bit) |
| rem_cnt | input | RC_W | Number of remaining bits |
| rem_bits | input | MAX_REM | Remaining bits, right-aligned, sent MSB-first |
| flush | input | 1 | Force held-back bits out |
| rd_en | input | 1 | Advance the read address |
| wr_en | output | 1 | Write strobe |
| wr_data | output | DATA_W | Write payload, first bit at the MSB |
| wr_width | output | WW | Number of valid payload bits |
| wr_addr | output | ADDR_W | Bit address of the first payload bit |
| rd_addr | output | ADDR_W | Sequential read address |

## Verification
The assertions assume that `follow_cnt` never exceeds MAX_FOLLOW and `rem_cnt` never exceeds MAX_REM, so that no payload can be wider than `wr_data`. They also assume that the address does not wrap within a run, so each start address follows from the previous one by simple addition. The stimulus draws counts only within those bounds. It uses few enough cycles and bits that the bit pointer stays far below its wrap point. Separate phases cover back-to-back symbols with no follow bits, flushes with and without a hold, flushes that coincide with a symbol, and junk in the unused remaining-bit positions.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  // Per-cycle request class decoded from sym_valid and flush
  typedef enum logic [1:0] {
    OP_IDLE      = 2'b00,
    OP_FLUSH     = 2'b01,
    OP_SYM       = 2'b10,
    OP_SYM_FLUSH = 2'b11
  } mbw_op_e;
endpackage

// File: rtl/mbw_hold.sv
module mbw_hold
  import mbw_pkg::*;
#(
  parameter int MAX_REM = 3,
  parameter int RC_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  mbw_op_e            op,
  input  logic [RC_W-1:0]    rem_cnt,
  input  logic [MAX_REM-1:0] rem_bits,
  output logic [RC_W-1:0]    hold_cnt,
  output logic [MAX_REM-1:0] hold_bits
);
  // Buffers one symbol's remaining bits until the next write
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt  <= '0;
      hold_bits <= '0;
    end else begin
      case (op)
        OP_SYM: begin
          hold_cnt  <= rem_cnt;
          hold_bits <= rem_bits;
        end
        OP_FLUSH, OP_SYM_FLUSH: begin
          hold_cnt  <= '0;
          hold_bits <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mbw_merge.sv
module mbw_merge #(
  parameter int MAX_FOLLOW = 7,
  parameter int MAX_REM    = 3,
  parameter int FC_W       = 3,
  parameter int RC_W       = 2,
  parameter int DATA_W     = 14,
  parameter int WW         = 4
) (
  input  logic [RC_W-1:0]    hold_cnt,
  input  logic [MAX_REM-1:0] hold_bits,
  input  logic               take_sym,
  input  logic               take_rem,
  input  logic               lead_bit,
  input  logic [FC_W-1:0]    follow_cnt,
  input  logic [RC_W-1:0]    rem_cnt,
  input  logic [MAX_REM-1:0] rem_bits,
  output logic [DATA_W-1:0]  data,
  output logic [WW-1:0]      width
);
  // Segment boundaries in emission order; the same values drive the width
  int b_hold, b_lead, b_foll, b_rem;

  always_comb begin
    b_hold = int'(hold_cnt);
    b_lead = b_hold + (take_sym ? 1 : 0);
    b_foll = b_lead + (take_sym ? int'(follow_cnt) : 0);
    b_rem  = b_foll + (take_rem ? int'(rem_cnt) : 0);
    width  = WW'(b_rem);
  end

  // One selector per output position; position g carries emission slot g
  for (genvar g = 0; g < DATA_W; g++) begin : g_slot
    always_comb begin
      if (g < b_hold)      data[DATA_W-1-g] = hold_bits[b_hold-1-g];
      else if (g < b_lead) data[DATA_W-1-g] = lead_bit;
      else if (g < b_foll) data[DATA_W-1-g] = ~lead_bit;
      else if (g < b_rem)  data[DATA_W-1-g] = rem_bits[b_rem-1-g];
      else                 data[DATA_W-1-g] = 1'b0;
    end
  end
endmodule

// File: rtl/mbw_addr.sv
module mbw_addr #(
  parameter int ADDR_W = 16,
  parameter int WW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_go,
  input  logic [WW-1:0]     wr_len,
  input  logic              rd_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [ADDR_W-1:0] bit_ptr;

  // Write start address is latched with the write; the pointer advance is deferred
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_ptr <= '0;
      wr_addr <= '0;
    end else if (wr_go) begin
      wr_addr <= bit_ptr;
      bit_ptr <= bit_ptr + ADDR_W'(wr_len);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_addr <= '0;
    else if (rd_en) rd_addr <= rd_addr + ADDR_W'(1);
  end
endmodule

// File: rtl/merged_bit_writer.sv
module merged_bit_writer
  import mbw_pkg::*;
#(
  parameter int MAX_FOLLOW = 7,
  parameter int MAX_REM    = 3,
  parameter int ADDR_W     = 16,
  localparam int FC_W      = $clog2(MAX_FOLLOW + 1),
  localparam int RC_W      = $clog2(MAX_REM + 1),
  localparam int DATA_W    = 2 * MAX_REM + 1 + MAX_FOLLOW,
  localparam int WW        = $clog2(DATA_W + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sym_valid,
  input  logic               lead_bit,
  input  logic [FC_W-1:0]    follow_cnt,
  input  logic [RC_W-1:0]    rem_cnt,
  input  logic [MAX_REM-1:0] rem_bits,
  input  logic               flush,
  input  logic               rd_en,
  output logic               wr_en,
  output logic [DATA_W-1:0]  wr_data,
  output logic [WW-1:0]      wr_width,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [ADDR_W-1:0]  rd_addr
);
  mbw_op_e            op;
  logic [RC_W-1:0]    hold_cnt;
  logic [MAX_REM-1:0] hold_bits;
  logic [DATA_W-1:0]  mrg_data;
  logic [WW-1:0]      mrg_width;
  logic               wr_go;

  assign op    = mbw_op_e'({sym_valid, flush});
  assign wr_go = sym_valid | (flush & (hold_cnt != '0));

  mbw_hold #(.MAX_REM(MAX_REM), .RC_W(RC_W)) u_hold (
    .clk(clk), .rst(rst), .op(op), .rem_cnt(rem_cnt), .rem_bits(rem_bits),
    .hold_cnt(hold_cnt), .hold_bits(hold_bits)
  );

  mbw_merge #(
    .MAX_FOLLOW(MAX_FOLLOW), .MAX_REM(MAX_REM), .FC_W(FC_W), .RC_W(RC_W),
    .DATA_W(DATA_W), .WW(WW)
  ) u_merge (
    .hold_cnt(hold_cnt), .hold_bits(hold_bits),
    .take_sym(sym_valid), .take_rem(op == OP_SYM_FLUSH),
    .lead_bit(lead_bit), .follow_cnt(follow_cnt),
    .rem_cnt(rem_cnt), .rem_bits(rem_bits),
    .data(mrg_data), .width(mrg_width)
  );

  mbw_addr #(.ADDR_W(ADDR_W), .WW(WW)) u_addr (
    .clk(clk), .rst(rst), .wr_go(wr_go), .wr_len(mrg_width), .rd_en(rd_en),
    .wr_addr(wr_addr), .rd_addr(rd_addr)
  );

  // Registered write port
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      wr_data  <= '0;
      wr_width <= '0;
    end else begin
      wr_en    <= wr_go;
      wr_data  <= wr_go ? mrg_data : '0;
      wr_width <= wr_go ? mrg_width : '0;
    end
  end
endmodule

// File: rtl/mbw_chk.sv
module mbw_chk #(
  parameter int DATA_W = 14,
  parameter int WW     = 4,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sym_valid,
  input logic              flush,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [WW-1:0]     wr_width,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] rd_addr
);
  logic [ADDR_W-1:0] next_start;
  logic [DATA_W-1:0] below_mask;

  always_ff @(posedge clk) begin
    if (rst)        next_start <= '0;
    else if (wr_en) next_start <= wr_addr + ADDR_W'(wr_width);
  end

  always_comb below_mask = {DATA_W{1'b1}} >> wr_width;

  // R2
  sym_write_chk: assert property (@(posedge clk) disable iff (rst)
    sym_valid |=> wr_en);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!sym_valid && !flush) |=> !wr_en);
  // R3
  width_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_width != '0) && (int'(wr_width) <= DATA_W));
  // R3
  tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((wr_data & below_mask) == '0));
  // R7
  addr_chain_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr == next_start));
  // R8
  rd_step_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_addr == $past(rd_addr) + ADDR_W'(1)));
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_addr));
endmodule

bind merged_bit_writer mbw_chk #(.DATA_W(DATA_W), .WW(WW), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .sym_valid(sym_valid), .flush(flush), .rd_en(rd_en),
  .wr_en(wr_en), .wr_data(wr_data), .wr_width(wr_width),
  .wr_addr(wr_addr), .rd_addr(rd_addr)
);

// File: tb/test_merged_bit_writer.sv
`timescale 1ns/1ps
module test_merged_bit_writer;
  localparam int MAXF = 7;
  localparam int MAXR = 3;
  localparam int AW   = 16;
  localparam int DW   = 2 * MAXR + 1 + MAXF;
  localparam int WW   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sym_valid = 1'b0, lead_bit = 1'b0, flush = 1'b0, rd_en = 1'b0;
  logic [2:0] follow_cnt = '0;
  logic [1:0] rem_cnt = '0;
  logic [MAXR-1:0] rem_bits = '0;
  logic wr_en;
  logic [DW-1:0] wr_data;
  logic [WW-1:0] wr_width;
  logic [AW-1:0] wr_addr, rd_addr;

  always #2.5 clk = ~clk;

  merged_bit_writer i_merged_bit_writer (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .lead_bit(lead_bit),
    .follow_cnt(follow_cnt), .rem_cnt(rem_cnt), .rem_bits(rem_bits),
    .flush(flush), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .wr_width(wr_width), .wr_addr(wr_addr), .rd_addr(rd_addr)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // Reference model state
  bit pq[$];
  int ptr = 0, exp_waddr = 0, exp_rd = 0;
  bit exp_en = 0;
  logic [DW-1:0] exp_data = '0;
  int exp_w = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit v, bit l, int fc, int rc, int rb, bit fl, bit re);
    bit e[$];
    sym_valid = v; lead_bit = l; follow_cnt = 3'(fc); rem_cnt = 2'(rc);
    rem_bits = MAXR'(rb); flush = fl; rd_en = re;
    e = {};
    exp_en = 0;
    if (v) begin
      e = pq;
      e.push_back(l);
      for (int k = 0; k < fc; k++) e.push_back(~l);
      pq = {};
      for (int k = rc - 1; k >= 0; k--) begin
        if (fl) e.push_back(rb[k]);
        else    pq.push_back(rb[k]);
      end
      exp_en = 1;
    end else if (fl && pq.size() > 0) begin
      e = pq;
      pq = {};
      exp_en = 1;
    end
    if (exp_en) begin
      exp_data = '0;
      for (int j = 0; j < e.size(); j++) exp_data[DW-1-j] = e[j];
      exp_w = e.size();
      exp_waddr = ptr;
      ptr += exp_w;
    end
    if (re) exp_rd = (exp_rd + 1) % (1 << AW);
    @(negedge clk);
    chk("R2", "wr_en", longint'(wr_en), longint'(exp_en));
    if (exp_en) begin
      chk(tag, "wr_data", longint'(wr_data), longint'(exp_data));
      chk(tag, "wr_width", longint'(wr_width), longint'(exp_w));
    end
    chk("R7", "wr_addr", longint'(wr_addr), longint'(exp_waddr));
    chk("R8", "rd_addr", longint'(rd_addr), longint'(exp_rd));
  endtask

  task automatic idle_all();
    sym_valid = 0; flush = 0; rd_en = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    idle_all();
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "wr_en", longint'(wr_en), 0);
    chk("R1", "wr_addr", longint'(wr_addr), 0);
    chk("R1", "rd_addr", longint'(rd_addr), 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "wr_en after", longint'(wr_en), 0);
    chk("R1", "rd_addr after", longint'(rd_addr), 0);
    // R1: a flush straight after reset finds nothing held
    step("R1", 0, 0, 0, 0, 0, 1, 0);
    // R3: widest symbol write without a hold
    step("R3", 1, 1, MAXF, 0, 0, 0, 1);
    // R6: full hold plus widest symbol plus its own remaining bits
    step("R3", 1, 0, 0, MAXR, 3'b101, 0, 0);
    step("R6", 1, 1, MAXF, MAXR, 3'b011, 1, 1);
    // R3: random symbols with gaps and clean remaining-bit fields
    for (int i = 0; i < 600; i++) begin
      int rc = $urandom_range(0, MAXR);
      step("R3", ($urandom_range(0, 9) < 7), 1'($urandom), $urandom_range(0, MAXF), rc,
           int'($urandom_range(0, 7)) & ((1 << rc) - 1), 0, 1'($urandom));
    end
    // R4: back-to-back symbols, no follow bits, remaining bits always present
    for (int i = 0; i < 300; i++)
      step("R4", 1, 1'($urandom), 0, $urandom_range(1, MAXR), 0 + int'($urandom_range(0, 7)) &
           ((1 << MAXR) - 1) & 7, 0, 1'($urandom));
    // R5: flushes with and without a hold
    step("R5", 1, 0, 1, 2, 3'b010, 0, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 0);
    for (int i = 0; i < 400; i++) begin
      bit v = 1'($urandom);
      int rc = $urandom_range(0, MAXR);
      step("R5", v, 1'($urandom), $urandom_range(0, MAXF), rc,
           int'($urandom_range(0, 7)) & ((1 << rc) - 1), (!v) && 1'($urandom), 1'($urandom));
    end
    // R6: flushes coinciding with symbols
    for (int i = 0; i < 400; i++) begin
      int rc = $urandom_range(0, MAXR);
      step("R6", 1, 1'($urandom), $urandom_range(0, MAXF), rc,
           int'($urandom_range(0, 7)) & ((1 << rc) - 1), 1'($urandom), 1'($urandom));
    end
    // R9: junk above rem_cnt in rem_bits
    for (int i = 0; i < 400; i++)
      step("R9", ($urandom_range(0, 9) < 8), 1'($urandom), $urandom_range(0, MAXF),
           $urandom_range(0, MAXR - 1), int'($urandom_range(0, 7)), ($urandom_range(0, 9) == 0),
           1'($urandom));
    // R8: long read run with writes idle
    for (int i = 0; i < 300; i++) step("R8", 0, 0, 0, 0, 0, 0, 1);
    done = 1;
    summary();
    $finish;
  end
endmodule